// File: doc/BRIEF.md
# Multi-Cycle 32-bit RISC Core

This block is a compact 32-bit processor for a small load/store instruction subset. It runs each instruction as a series of short steps that share hardware. One adder/logic unit computes the sequential program counter, the branch target and the instruction's own result, each in a different step. One word-wide memory supplies both instruction fetches and data accesses. The results of the steps are kept in holding registers: instruction, memory data, two operands and the unit's result.

Each instruction leaves the step sequence as soon as it has finished its work. Jumps take two cycles, conditional branches three, stores and ordinary arithmetic four, and loads five.

A testbench or boot agent writes the memory image through a dedicated load port while the core is held in reset. A read-only peek port returns any memory word at any time, so the results a program stores can be inspected. The current step code, program counter, instruction register and result register are brought out for observation.

Top module: `mc_core`

## Requirements
- R1: The step code on `phase_o` is fetch=0, decode=1, execute=2, memory=3, writeback=4. Reset forces fetch and clears PC, IR and all registers. Decode is always entered directly from fetch, and an unused code returns to fetch.
- R2: In fetch the core loads IR from the memory word at PC bits 7:2 and loads PC with PC+4, both computed in the same cycle. During the following decode step, `ir_o` shows that word and `pc_o` shows PC+4.
- R3: The jumps finish in decode, giving 2 cycles from one decode to the next. These are j (opcode 0x02), jal (opcode 0x03) and jr (opcode 0 with function 0x08). j and jal load {PC+4[31:28], target[25:0], 00}. jr loads register rs. jal also writes PC+4 into register 31.
- R4: beq (0x04) and bne (0x05) take 3 cycles. During execute, `alu_o` holds PC+4 + (sign-extended offset << 2), which was computed in decode. PC takes that value only when the operands are equal (beq) or unequal (bne).
- R5: lw (0x23) and sw (0x2B) form the address as rs + sign-extended offset, and `alu_o` shows that address in the memory step. sw writes the word at address bits 7:2 and takes 4 cycles. lw writes the word into rt and takes 5 cycles.
- R6: addi (0x08) sign-extends its immediate, and andi (0x0C), ori (0x0D) and xori (0x0E) zero-extend theirs. lui (0x0F) places the immediate in bits 31:16. The result goes to rt, and each of these takes 4 cycles.
- R7: Register-type add (0x20), sub (0x22), and (0x24), or (0x25) and xor (0x26) write rs op rt into rd in 4 cycles. The opcode of all register-type instructions is 0.
- R8: sll (0x00), srl (0x02) and sra (0x03) shift rt by the 5-bit amount in instruction bits 10:6 and write the result to rd. srl fills with zeros and sra copies the sign bit.
- R9: Register 0 always reads as zero, and a write to it has no effect.
- R10: While `load_we` is high, `load_word` is written to memory word `load_idx` at the clock edge. `peek_word` returns memory word `peek_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_we | input | 1 | Memory preload write enable |
| load_idx | input | 6 | Preload word index |
| load_word | input | 32 | Preload data |
| peek_idx | input | 6 | Inspection word index |
| peek_word | output | 32 | Memory word at `peek_idx` |
| phase_o | output | 3 | Current step code |
| pc_o | output | 32 | Program counter |
| ir_o | output | 32 | Instruction register |
| alu_o | output | 32 | Result holding register |

## Verification
The bench runs a program that sums four words through a call and a return. It also exercises a taken and an untaken beq, a bne loop and a chain of shifts, and writes to register 0. A core that let an instruction run through extra steps, or left one too early, would break the measured cycle count between successive decodes. A branch that compared with the wrong polarity, or used a target offset that was not shifted, would break the expected fetch sequence. A core that sign-extended a logical immediate, shifted by the wrong field, or let register 0 keep a value would leave wrong words in the result area that the peek port reads back.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [2:0] {
    ST_IF  = 3'd0,
    ST_ID  = 3'd1,
    ST_EXE = 3'd2,
    ST_MEM = 3'd3,
    ST_WB  = 3'd4
  } phase_e;

  typedef enum logic [4:0] {
    K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_SLL, K_SRL, K_SRA, K_JR,
    K_ADDI, K_ANDI, K_ORI, K_XORI, K_LUI, K_LW, K_SW,
    K_BEQ, K_BNE, K_J, K_JAL, K_BAD
  } kind_e;

  typedef enum logic [1:0] {SA_PC, SA_RS, SA_SHAMT}          src_a_e;
  typedef enum logic [1:0] {SB_FOUR, SB_RT, SB_IMM, SB_BOFF} src_b_e;
  typedef enum logic [1:0] {PS_ALU, PS_HELD, PS_RS, PS_JUMP} pc_src_e;
  typedef enum logic [1:0] {WD_RES, WD_MDR, WD_LINK}         wd_src_e;

  localparam logic [3:0] AOP_ADD = 4'b0000;
  localparam logic [3:0] AOP_SUB = 4'b0100;
  localparam logic [3:0] AOP_AND = 4'b0001;
  localparam logic [3:0] AOP_OR  = 4'b0101;
  localparam logic [3:0] AOP_XOR = 4'b0010;
  localparam logic [3:0] AOP_LUI = 4'b0110;
  localparam logic [3:0] AOP_SLL = 4'b0011;
  localparam logic [3:0] AOP_SRL = 4'b0111;
  localparam logic [3:0] AOP_SRA = 4'b1111;

  typedef struct packed {
    logic    pc_we;
    logic    ir_we;
    logic    res_we;
    logic    mem_we;
    logic    rf_we;
    logic    addr_res;
    logic    dst_rt;
    logic    dst_link;
    logic    zext;
    src_a_e  sa;
    src_b_e  sb;
    pc_src_e ps;
    wd_src_e wd;
    logic [3:0] aluop;
  } ctrl_t;

  function automatic kind_e decode(input logic [31:0] w);
    kind_e k;
    k = K_BAD;
    case (w[31:26])
      6'h00: begin
        case (w[5:0])
          6'h20: k = K_ADD;
          6'h22: k = K_SUB;
          6'h24: k = K_AND;
          6'h25: k = K_OR;
          6'h26: k = K_XOR;
          6'h00: k = K_SLL;
          6'h02: k = K_SRL;
          6'h03: k = K_SRA;
          6'h08: k = K_JR;
          default: k = K_BAD;
        endcase
      end
      6'h08: k = K_ADDI;
      6'h0C: k = K_ANDI;
      6'h0D: k = K_ORI;
      6'h0E: k = K_XORI;
      6'h0F: k = K_LUI;
      6'h23: k = K_LW;
      6'h2B: k = K_SW;
      6'h04: k = K_BEQ;
      6'h05: k = K_BNE;
      6'h02: k = K_J;
      6'h03: k = K_JAL;
      default: k = K_BAD;
    endcase
    return k;
  endfunction

  function automatic logic [3:0] exe_op(input kind_e k);
    case (k)
      K_SUB, K_BEQ, K_BNE: return AOP_SUB;
      K_AND, K_ANDI:       return AOP_AND;
      K_OR,  K_ORI:        return AOP_OR;
      K_XOR, K_XORI:       return AOP_XOR;
      K_LUI:               return AOP_LUI;
      K_SLL:               return AOP_SLL;
      K_SRL:               return AOP_SRL;
      K_SRA:               return AOP_SRA;
      default:             return AOP_ADD;
    endcase
  endfunction

  function automatic logic [31:0] alu_calc(input logic [31:0] a, input logic [31:0] b,
                                           input logic [3:0] op);
    logic [31:0] r;
    casez (op)
      4'b?000: r = a + b;
      4'b?100: r = a - b;
      4'b?001: r = a & b;
      4'b?101: r = a | b;
      4'b?010: r = a ^ b;
      4'b?110: r = {b[15:0], 16'h0000};
      4'b?011: r = b << a[4:0];
      4'b0111: r = b >> a[4:0];
      default: r = $signed(b) >>> a[4:0];
    endcase
    return r;
  endfunction

  function automatic logic [31:0] extend16(input logic [15:0] v, input logic zext);
    return {{16{v[15] & ~zext}}, v};
  endfunction

  function automatic logic [31:0] branch_off(input logic [15:0] v);
    return {{14{v[15]}}, v, 2'b00};
  endfunction

  function automatic logic [31:0] jump_addr(input logic [31:0] pc, input logic [25:0] t);
    return {pc[31:28], t, 2'b00};
  endfunction

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W = 32,
  parameter int N = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [$clog2(N)-1:0] ra,
  input  logic [$clog2(N)-1:0] rb,
  input  logic [$clog2(N)-1:0] wa,
  input  logic                 we,
  input  logic [W-1:0]         wd,
  output logic [W-1:0]         qa,
  output logic [W-1:0]         qb
);
  logic [W-1:0] regs [1:N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i < N; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign qa = (ra == '0) ? '0 : regs[ra];
  assign qb = (rb == '0) ? '0 : regs[rb];
endmodule

// File: rtl/mc_alu.sv
module mc_alu import mc_pkg::*; (
  input  logic [31:0] a,
  input  logic [31:0] b,
  input  logic [3:0]  op,
  output logic [31:0] y,
  output logic        zero
);
  assign y    = alu_calc(a, b, op);
  assign zero = ~|y;
endmodule

// File: rtl/mc_mem.sv
module mc_mem #(
  parameter int WORDS = 64
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] idx,
  input  logic [31:0]              wdata,
  output logic [31:0]              rdata,
  input  logic                     ld_we,
  input  logic [$clog2(WORDS)-1:0] ld_idx,
  input  logic [31:0]              ld_data,
  input  logic [$clog2(WORDS)-1:0] pk_idx,
  output logic [31:0]              pk_data
);
  logic [31:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (ld_we)   cells[ld_idx] <= ld_data;
    else if (we) cells[idx]    <= wdata;
  end

  assign rdata   = cells[idx];
  assign pk_data = cells[pk_idx];
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl import mc_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ir,
  input  logic        zero,
  output phase_e      state,
  output ctrl_t       ctl
);
  kind_e  kind;
  phase_e nxt;
  logic   is_jump, is_branch, is_mem, is_imm, is_shift, is_logic_imm;

  assign kind         = decode(ir);
  assign is_jump      = (kind == K_J) || (kind == K_JAL) || (kind == K_JR);
  assign is_branch    = (kind == K_BEQ) || (kind == K_BNE);
  assign is_mem       = (kind == K_LW) || (kind == K_SW);
  assign is_logic_imm = (kind == K_ANDI) || (kind == K_ORI) || (kind == K_XORI);
  assign is_imm       = is_logic_imm || (kind == K_ADDI) || (kind == K_LUI);
  assign is_shift     = (kind == K_SLL) || (kind == K_SRL) || (kind == K_SRA);

  always_comb begin
    ctl.pc_we    = 1'b0;
    ctl.ir_we    = 1'b0;
    ctl.res_we   = 1'b0;
    ctl.mem_we   = 1'b0;
    ctl.rf_we    = 1'b0;
    ctl.addr_res = 1'b0;
    ctl.dst_rt   = 1'b0;
    ctl.dst_link = 1'b0;
    ctl.zext     = 1'b0;
    ctl.sa       = SA_PC;
    ctl.sb       = SB_FOUR;
    ctl.ps       = PS_ALU;
    ctl.wd       = WD_RES;
    ctl.aluop    = AOP_ADD;
    nxt          = ST_IF;
    case (state)
      ST_IF: begin
        ctl.pc_we = 1'b1;
        ctl.ir_we = 1'b1;
        nxt       = ST_ID;
      end
      ST_ID: begin
        if (is_jump) begin
          ctl.pc_we = 1'b1;
          ctl.ps    = (kind == K_JR) ? PS_RS : PS_JUMP;
          if (kind == K_JAL) begin
            ctl.rf_we    = 1'b1;
            ctl.dst_link = 1'b1;
            ctl.wd       = WD_LINK;
          end
          nxt = ST_IF;
        end else begin
          ctl.sb     = SB_BOFF;
          ctl.res_we = 1'b1;
          nxt        = ST_EXE;
        end
      end
      ST_EXE: begin
        ctl.aluop = exe_op(kind);
        ctl.sa    = SA_RS;
        ctl.sb    = SB_RT;
        if (is_branch) begin
          ctl.ps    = PS_HELD;
          ctl.pc_we = (kind == K_BEQ) ? zero : ~zero;
          nxt       = ST_IF;
        end else if (is_mem) begin
          ctl.sb     = SB_IMM;
          ctl.res_we = 1'b1;
          nxt        = ST_MEM;
        end else if (kind == K_BAD) begin
          nxt = ST_IF;
        end else begin
          ctl.res_we = 1'b1;
          ctl.zext   = is_logic_imm;
          if (is_shift) ctl.sa = SA_SHAMT;
          if (is_imm)   ctl.sb = SB_IMM;
          nxt = ST_WB;
        end
      end
      ST_MEM: begin
        ctl.addr_res = 1'b1;
        if (kind == K_LW) begin
          nxt = ST_WB;
        end else begin
          ctl.mem_we = 1'b1;
          nxt        = ST_IF;
        end
      end
      ST_WB: begin
        ctl.rf_we  = 1'b1;
        ctl.dst_rt = is_imm || (kind == K_LW);
        ctl.wd     = (kind == K_LW) ? WD_MDR : WD_RES;
        nxt        = ST_IF;
      end
      default: nxt = ST_IF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IF;
    else        state <= nxt;
  end

  AST_ID_AFTER_IF: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_ID |-> $past(state) == ST_IF); // R1
  AST_JUMP_LEAVES_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ID && is_jump) |=> state == ST_IF); // R3
  AST_BRANCH_LEAVES_EXE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXE && is_branch) |=> state == ST_IF); // R4
  AST_STORE_LEAVES_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MEM && kind == K_SW) |=> state == ST_IF); // R5
endmodule

// File: rtl/mc_core.sv
module mc_core import mc_pkg::*; #(
  parameter int MEM_WORDS = 64,
  parameter int NREGS     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load_we,
  input  logic [$clog2(MEM_WORDS)-1:0] load_idx,
  input  logic [31:0]                  load_word,
  input  logic [$clog2(MEM_WORDS)-1:0] peek_idx,
  output logic [31:0]                  peek_word,
  output logic [2:0]                   phase_o,
  output logic [31:0]                  pc_o,
  output logic [31:0]                  ir_o,
  output logic [31:0]                  alu_o
);
  localparam int IDX_W = $clog2(MEM_WORDS);
  localparam int RA_W  = $clog2(NREGS);

  phase_e      state;
  ctrl_t       ctl;
  logic [31:0] pc_q, ir_q, mdr_q, a_q, b_q, res_q;
  logic [31:0] rf_qa, rf_qb, alu_a, alu_b, alu_y, pc_next, rf_wd, mem_addr, mem_rd;
  logic [RA_W-1:0] rf_wa;
  logic        zero;

  mc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ir(ir_q), .zero(zero), .state(state), .ctl(ctl)
  );

  always_comb begin
    case (ctl.sa)
      SA_RS:    alu_a = a_q;
      SA_SHAMT: alu_a = {27'd0, ir_q[10:6]};
      default:  alu_a = pc_q;
    endcase
    case (ctl.sb)
      SB_RT:   alu_b = b_q;
      SB_IMM:  alu_b = extend16(ir_q[15:0], ctl.zext);
      SB_BOFF: alu_b = branch_off(ir_q[15:0]);
      default: alu_b = 32'd4;
    endcase
    case (ctl.ps)
      PS_HELD: pc_next = res_q;
      PS_RS:   pc_next = rf_qa;
      PS_JUMP: pc_next = jump_addr(pc_q, ir_q[25:0]);
      default: pc_next = alu_y;
    endcase
    case (ctl.wd)
      WD_MDR:  rf_wd = mdr_q;
      WD_LINK: rf_wd = pc_q;
      default: rf_wd = res_q;
    endcase
  end

  mc_alu u_alu (.a(alu_a), .b(alu_b), .op(ctl.aluop), .y(alu_y), .zero(zero));

  assign rf_wa = (ctl.dst_rt ? ir_q[20:16] : ir_q[15:11]) | {RA_W{ctl.dst_link}};

  mc_regfile #(.W(32), .N(NREGS)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra(ir_q[25:21]), .rb(ir_q[20:16]), .wa(rf_wa),
    .we(ctl.rf_we), .wd(rf_wd), .qa(rf_qa), .qb(rf_qb)
  );

  assign mem_addr = ctl.addr_res ? res_q : pc_q;

  logic unused_addr_bits;
  assign unused_addr_bits = ^{mem_addr[31:IDX_W+2], mem_addr[1:0]};

  mc_mem #(.WORDS(MEM_WORDS)) u_mem (
    .clk(clk), .we(ctl.mem_we), .idx(mem_addr[IDX_W+1:2]), .wdata(b_q), .rdata(mem_rd),
    .ld_we(load_we), .ld_idx(load_idx), .ld_data(load_word),
    .pk_idx(peek_idx), .pk_data(peek_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mdr_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
    end else begin
      a_q   <= rf_qa;
      b_q   <= rf_qb;
      mdr_q <= mem_rd;
      if (ctl.pc_we)  pc_q  <= pc_next;
      if (ctl.ir_we)  ir_q  <= mem_rd;
      if (ctl.res_we) res_q <= alu_y;
    end
  end

  assign phase_o = state;
  assign pc_o    = pc_q;
  assign ir_o    = ir_q;
  assign alu_o   = res_q;

  AST_IR_ONLY_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ir_q) |-> $past(state) == ST_IF); // R2
endmodule

// File: tb/mc_core_test.sv
module mc_core_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_we = 1'b0;
  logic [5:0]  load_idx = '0;
  logic [31:0] load_word = '0;
  logic [5:0]  peek_idx = '0;
  logic [31:0] peek_word;
  logic [2:0]  phase_o;
  logic [31:0] pc_o, ir_o, alu_o;

  mc_core uut (
    .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_idx(load_idx), .load_word(load_word),
    .peek_idx(peek_idx), .peek_word(peek_word), .phase_o(phase_o),
    .pc_o(pc_o), .ir_o(ir_o), .alu_o(alu_o)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [31:0] img [64];
  logic [31:0] ref_rf [32];
  logic [31:0] ref_pc;

  logic [31:0] q_pc4[$], q_ir[$], q_tgt[$];
  int          q_len[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                        input int sh, input logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                        input logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction
  function automatic logic [31:0] enc_j(input logic [5:0] op, input int word);
    return {op, word[25:0]};
  endfunction

  function automatic string req_of(input logic [31:0] w);
    case (w[31:26])
      6'h00: begin
        if (w[5:0] == 6'h08) return "R3";
        if (w[5:0] == 6'h00 || w[5:0] == 6'h02 || w[5:0] == 6'h03) return "R8";
        return "R7";
      end
      6'h02, 6'h03: return "R3";
      6'h04, 6'h05: return "R4";
      6'h23, 6'h2B: return "R5";
      default:      return "R6";
    endcase
  endfunction

  // Scoreboard driver: instruction-level model pushes one expected item per instruction
  task automatic iss_step();
    logic [31:0] w, pc4, nxt, a, b, res, sx, ad, tg;
    logic [4:0]  dst, sh;
    bit          wr;
    int          len;
    w   = img[ref_pc[7:2]];
    pc4 = ref_pc + 32'd4;
    nxt = pc4;
    a   = (w[25:21] == 0) ? 32'd0 : ref_rf[w[25:21]];
    b   = (w[20:16] == 0) ? 32'd0 : ref_rf[w[20:16]];
    sx  = {{16{w[15]}}, w[15:0]};
    sh  = w[10:6];
    wr = 0; dst = w[20:16]; res = 0; len = 4; tg = 0;
    case (w[31:26])
      6'h00: begin
        wr = 1; dst = w[15:11];
        case (w[5:0])
          6'h20: res = a + b;
          6'h22: res = a - b;
          6'h24: res = a & b;
          6'h25: res = a | b;
          6'h26: res = a ^ b;
          6'h00: res = b << sh;
          6'h02: res = b >> sh;
          6'h03: res = $signed(b) >>> sh;
          default: begin wr = 0; nxt = a; len = 2; end
        endcase
      end
      6'h08: begin wr = 1; res = a + sx; end
      6'h0C: begin wr = 1; res = a & {16'h0, w[15:0]}; end
      6'h0D: begin wr = 1; res = a | {16'h0, w[15:0]}; end
      6'h0E: begin wr = 1; res = a ^ {16'h0, w[15:0]}; end
      6'h0F: begin wr = 1; res = {w[15:0], 16'h0}; end
      6'h23: begin ad = a + sx; wr = 1; res = img[ad[7:2]]; len = 5; tg = ad; end
      6'h2B: begin ad = a + sx; img[ad[7:2]] = b; tg = ad; end
      6'h04, 6'h05: begin
        tg = pc4 + {sx[29:0], 2'b00}; len = 3;
        if ((a == b) == (w[31:26] == 6'h04)) nxt = tg;
      end
      6'h02: begin nxt = {pc4[31:28], w[25:0], 2'b00}; len = 2; end
      6'h03: begin nxt = {pc4[31:28], w[25:0], 2'b00}; len = 2; ref_rf[31] = pc4; end
      default: ;
    endcase
    if (wr && dst != 0) ref_rf[dst] = res;
    q_pc4.push_back(pc4);
    q_ir.push_back(w);
    q_len.push_back(len);
    q_tgt.push_back(tg);
    ref_pc = nxt;
  endtask

  // Monitor: pops one item at each decode step and compares what the core shows
  int          cyc = 0, prev_cyc = 0, prev_len = 0;
  bit          have_prev = 0, live = 0;
  logic [31:0] cur_ir = '0, cur_tgt = '0;

  always @(negedge clk) begin
    if (rst_n && live) begin
      cyc++;
      if (phase_o == 3'd1 && q_ir.size() > 0) begin
        if (have_prev)
          chk((cyc - prev_cyc) == prev_len, req_of(cur_ir), "cycles per instruction",
              32'(cyc - prev_cyc), 32'(prev_len));
        cur_ir   = q_ir.pop_front();
        cur_tgt  = q_tgt.pop_front();
        prev_len = q_len.pop_front();
        chk(ir_o == cur_ir, "R2", "fetched word", ir_o, cur_ir);
        chk(pc_o == q_pc4[0], "R2", "pc after fetch", pc_o, q_pc4[0]);
        void'(q_pc4.pop_front());
        prev_cyc  = cyc;
        have_prev = 1;
      end else if (phase_o == 3'd2 && (cur_ir[31:26] == 6'h04 || cur_ir[31:26] == 6'h05)) begin
        chk(alu_o == cur_tgt, "R4", "branch target held", alu_o, cur_tgt);
      end else if (phase_o == 3'd3) begin
        chk(alu_o == cur_tgt, "R5", "memory address", alu_o, cur_tgt);
      end
    end
  end

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 50000);
    n_chk++;
    n_err++;
    $display("FAIL R2 watchdog: actual %0d items left expected 0", q_ir.size());
    report();
  end

  initial begin
    for (int i = 0; i < 64; i++) img[i] = 32'd0;
    for (int i = 0; i < 32; i++) ref_rf[i] = 32'd0;
    ref_pc = 32'd0;
    img[0]  = enc_i(6'h0F, 0, 1, 16'h1234);
    img[1]  = enc_i(6'h0D, 0, 4, 16'h00C0);
    img[2]  = enc_i(6'h08, 0, 5, 16'd4);
    img[3]  = enc_j(6'h03, 24);
    img[4]  = enc_i(6'h2B, 0, 2, 16'h00E0);
    img[5]  = enc_i(6'h23, 0, 9, 16'h00E0);
    img[6]  = enc_r(9, 1, 8, 0, 6'h22);
    img[7]  = enc_i(6'h2B, 0, 8, 16'h00E4);
    img[8]  = enc_i(6'h08, 0, 9, 16'hFFFF);
    img[9]  = enc_i(6'h0C, 9, 10, 16'hFFFF);
    img[10] = enc_i(6'h0E, 10, 11, 16'h5555);
    img[11] = enc_r(10, 11, 12, 0, 6'h26);
    img[12] = enc_r(0, 9, 13, 15, 6'h00);
    img[13] = enc_r(0, 13, 14, 4, 6'h03);
    img[14] = enc_r(0, 13, 15, 16, 6'h02);
    img[15] = enc_r(14, 15, 16, 0, 6'h24);
    img[16] = enc_i(6'h2B, 0, 16, 16'h00E8);
    img[17] = enc_i(6'h08, 0, 0, 16'd5);
    img[18] = enc_i(6'h2B, 0, 0, 16'h00EC);
    img[19] = enc_i(6'h04, 12, 10, 16'd2);
    img[20] = enc_i(6'h04, 16, 16, 16'd1);
    img[21] = enc_i(6'h2B, 0, 9, 16'h00F0);
    img[22] = enc_i(6'h2B, 0, 12, 16'h00F4);
    img[23] = enc_j(6'h02, 23);
    img[24] = enc_r(0, 0, 8, 0, 6'h20);
    img[25] = enc_i(6'h23, 4, 9, 16'd0);
    img[26] = enc_i(6'h08, 4, 4, 16'd4);
    img[27] = enc_r(8, 9, 8, 0, 6'h20);
    img[28] = enc_i(6'h08, 5, 5, 16'hFFFF);
    img[29] = enc_i(6'h05, 5, 0, 16'hFFFB);
    img[30] = enc_r(8, 0, 2, 0, 6'h25);
    img[31] = enc_r(31, 0, 0, 0, 6'h08);
    img[48] = 32'h000000A3;
    img[49] = 32'h00000027;
    img[50] = 32'h00000079;
    img[51] = 32'h00000115;

    // R10: preload while held in reset
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      load_we = 1'b1; load_idx = 6'(i); load_word = img[i];
    end
    @(negedge clk);
    load_we = 1'b0;
    peek_idx = 6'd3;  #1 chk(peek_word == img[3],  "R10", "peek word 3",  peek_word, img[3]);
    peek_idx = 6'd51; #1 chk(peek_word == img[51], "R10", "peek word 51", peek_word, img[51]);
    // R1: reset state
    chk(phase_o == 3'd0, "R1", "reset phase", 32'(phase_o), 32'd0);
    chk(pc_o == 32'd0,   "R1", "reset pc",    pc_o, 32'd0);
    chk(ir_o == 32'd0,   "R1", "reset ir",    ir_o, 32'd0);

    for (int i = 0; i < 90; i++) iss_step();

    @(negedge clk);
    rst_n = 1'b1;
    live  = 1'b1;
    wait (q_ir.size() == 0);
    repeat (6) @(negedge clk);

    // Result area read back through the peek port
    for (int i = 48; i < 64; i++) begin
      peek_idx = 6'(i);
      #1 chk(peek_word == img[i], "R5", "memory image vs model", peek_word, img[i]);
    end
    peek_idx = 6'd56; #1 chk(peek_word == 32'h00000258, "R5", "sum of four words", peek_word, 32'h00000258);
    peek_idx = 6'd57; #1 chk(peek_word == 32'hEDCC0258, "R6", "lui then sub", peek_word, 32'hEDCC0258);
    peek_idx = 6'd58; #1 chk(peek_word == 32'h0000F800, "R8", "shift chain", peek_word, 32'h0000F800);
    peek_idx = 6'd59; #1 chk(peek_word == 32'h00000000, "R9", "register 0 stays zero", peek_word, 32'h0);
    peek_idx = 6'd60; #1 chk(peek_word == 32'h00000000, "R4", "skipped store", peek_word, 32'h0);
    peek_idx = 6'd61; #1 chk(peek_word == 32'h00005555, "R7", "xor result", peek_word, 32'h00005555);
    chk(pc_o == 32'h00000060, "R3", "self jump pc", pc_o, 32'h00000060);
    report();
  end
endmodule